// File: doc/BRIEF.md
# Interrupt Mask and Priority Controller

This block holds the two interrupt mask flags of a processor core and decides which pending request the core takes next. One flag (X) gates a single non-maskable request line. The other flag (I) gates a vector of maskable request lines that have a fixed priority among themselves. The block drives a combinational take request toward the sequencer. When the sequencer starts servicing, it pulses an entry strobe. The block then samples the winning source into registers that hold still through the vector fetch. In the same edge it raises the mask flags that the taken source calls for.

The X flag comes out of reset set. Software writes can clear it but can never set it again. A return from an interrupt handler can restore it, along with I, from the saved flags byte. The non-maskable request sees only X, and it wins over every maskable source.

Top module: `irq_mask_arbiter`

## Requirements
- R1: While reset is low, both x_mask and i_mask read 1, take_irq reads 0 whatever the request lines show, sel_idx reads 0 and sel_nmi reads 0.
- R2: A software write (sw_wr=1) with sw_x=0 clears x_mask on the next edge. A software write with sw_x=1 leaves x_mask at its present value, so a cleared X stays cleared.
- R3: A software write loads i_mask from sw_i on the next edge, whether that value is 0 or 1.
- R4: take_irq is 1 whenever nmi_req=1 and x_mask=0, regardless of i_mask.
- R5: Maskable requests raise take_irq only while i_mask=0. With i_mask=1 and no unmasked non-maskable request, take_irq is 0.
- R6: When the non-maskable request is unmasked and pending at an entry strobe, it is selected over any maskable request: sel_nmi becomes 1 and sel_idx becomes 0.
- R7: When a maskable source is selected, sel_idx becomes the lowest set index among mreq (bit 0 has the highest priority) and sel_nmi becomes 0.
- R8: Taking a maskable source sets i_mask and leaves x_mask unchanged.
- R9: Taking the non-maskable source sets both x_mask and i_mask.
- R10: A return strobe (rti_stb=1) loads x_mask from rti_x and i_mask from rti_i on the next edge. This can set x_mask to 1.
- R11: sel_idx and sel_nmi change only on an edge where entry_stb=1 and take_irq=1. They hold their values in every other cycle.
- R12: An entry strobe while take_irq=0 changes neither the masks nor the selection.
- R13: Within one cycle, an entry that is taken overrides a return strobe, and a return strobe overrides a software write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_req | input | 1 | Non-maskable request level |
| mreq | input | NUM_SRC | Maskable request levels, bit 0 highest priority |
| sw_wr | input | 1 | Software write of the mask flags |
| sw_x | input | 1 | Written X value (only 0 has effect) |
| sw_i | input | 1 | Written I value |
| entry_stb | input | 1 | Service-entry strobe from the sequencer |
| rti_stb | input | 1 | Return-from-interrupt restore strobe |
| rti_x | input | 1 | Saved X value to restore |
| rti_i | input | 1 | Saved I value to restore |
| x_mask | output | 1 | Current non-maskable gate flag |
| i_mask | output | 1 | Current maskable gate flag |
| take_irq | output | 1 | An unmasked request is pending |
| sel_idx | output | IDXW | Selected maskable index, sampled at entry |
| sel_nmi | output | 1 | Selection is the non-maskable source, sampled at entry |

## Verification
The bench first tries to set X again through a software write after software has cleared it. A design that treated X like I would re-mask the non-maskable line there. It then raises the non-maskable request with I still set, which catches a gate that wrongly ANDs in I. It also raises it together with maskable requests, so that a reversed priority picks a maskable index instead. Further cases fire an entry strobe with nothing pending, which a careless capture would treat as a fresh selection or a mask change. Others restore X to 1 through the return path, and pit the return strobe against a software write and the entry strobe in the same cycle; a different precedence would leave the wrong flags.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  // Which source updates the mask flags in a given cycle
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_SW    = 2'd1,
    UPD_RTI   = 2'd2,
    UPD_ENTRY = 2'd3
  } upd_e;

  typedef struct packed {
    logic x;
    logic i;
  } mask_t;

  localparam mask_t MASK_RESET = '{x: 1'b1, i: 1'b1};
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 8,
  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               nmi_req,
  input  logic [NUM_SRC-1:0] mreq,
  input  logic               x_mask,
  input  logic               i_mask,
  output logic               nmi_win,
  output logic               mask_win,
  output logic               take,
  output logic [IDXW-1:0]    win_idx
);
  // Lowest set index; 0 when none set
  function automatic logic [IDXW-1:0] lowest_set(input logic [NUM_SRC-1:0] v);
    logic [IDXW-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (v[k] && !found) begin
        r = IDXW'(k);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  logic nmi_open;
  logic any_mask;

  assign nmi_open = nmi_req & ~x_mask;
  assign any_mask = (|mreq) & ~i_mask;
  assign nmi_win  = nmi_open;
  assign mask_win = any_mask & ~nmi_open;
  assign take     = nmi_open | any_mask;
  assign win_idx  = nmi_open ? '0 : lowest_set(mreq);
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_mask_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  upd_e  upd,
  input  logic  sw_x,
  input  logic  sw_i,
  input  logic  rti_x,
  input  logic  rti_i,
  input  logic  nmi_win,
  output logic  x_mask,
  output logic  i_mask
);
  mask_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    unique case (upd)
      UPD_ENTRY: begin
        nxt.i = 1'b1;
        if (nmi_win) nxt.x = 1'b1;
      end
      UPD_RTI: begin
        nxt.x = rti_x;
        nxt.i = rti_i;
      end
      UPD_SW: begin
        // software may only clear X
        nxt.x = cur_q.x & sw_x;
        nxt.i = sw_i;
      end
      default: nxt = cur_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= MASK_RESET;
    else        cur_q <= nxt;
  end

  assign x_mask = cur_q.x;
  assign i_mask = cur_q.i;
endmodule

// File: rtl/irq_sel_latch.sv
module irq_sel_latch #(
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap,
  input  logic            nmi_win,
  input  logic [IDXW-1:0] win_idx,
  output logic [IDXW-1:0] sel_idx,
  output logic            sel_nmi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx <= '0;
      sel_nmi <= 1'b0;
    end else if (cap) begin
      sel_idx <= win_idx;
      sel_nmi <= nmi_win;
    end
  end
endmodule

// File: rtl/irq_mask_arbiter.sv
module irq_mask_arbiter
  import irq_mask_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_req,
  input  logic [NUM_SRC-1:0] mreq,
  input  logic               sw_wr,
  input  logic               sw_x,
  input  logic               sw_i,
  input  logic               entry_stb,
  input  logic               rti_stb,
  input  logic               rti_x,
  input  logic               rti_i,
  output logic               x_mask,
  output logic               i_mask,
  output logic               take_irq,
  output logic [IDXW-1:0]    sel_idx,
  output logic               sel_nmi
);
  logic            nmi_win;
  logic            mask_win;
  logic [IDXW-1:0] win_idx;
  logic            entry_taken;
  upd_e            upd;

  irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
    .nmi_req  (nmi_req),
    .mreq     (mreq),
    .x_mask   (x_mask),
    .i_mask   (i_mask),
    .nmi_win  (nmi_win),
    .mask_win (mask_win),
    .take     (take_irq),
    .win_idx  (win_idx)
  );

  assign entry_taken = entry_stb & take_irq;

  // precedence: taken entry, then return, then software write
  always_comb begin
    if (entry_taken)  upd = UPD_ENTRY;
    else if (rti_stb) upd = UPD_RTI;
    else if (sw_wr)   upd = UPD_SW;
    else              upd = UPD_NONE;
  end

  irq_mask_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd),
    .sw_x    (sw_x),
    .sw_i    (sw_i),
    .rti_x   (rti_x),
    .rti_i   (rti_i),
    .nmi_win (nmi_win),
    .x_mask  (x_mask),
    .i_mask  (i_mask)
  );

  irq_sel_latch #(.IDXW(IDXW)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (entry_taken),
    .nmi_win (nmi_win),
    .win_idx (win_idx),
    .sel_idx (sel_idx),
    .sel_nmi (sel_nmi)
  );
endmodule

// File: rtl/irq_mask_arbiter_chk.sv
module irq_mask_arbiter_chk #(
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            nmi_req,
  input logic            any_req,
  input logic            sw_wr,
  input logic            entry_stb,
  input logic            rti_stb,
  input logic            rti_x,
  input logic            rti_i,
  input logic            x_mask,
  input logic            i_mask,
  input logic            take_irq,
  input logic            nmi_win,
  input logic            mask_win,
  input logic [IDXW-1:0] sel_idx,
  input logic            sel_nmi
);
  // R2
  x_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !entry_stb && !rti_stb && !x_mask) |=> !x_mask);

  // R4
  nmi_open_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !x_mask) |-> take_irq);

  // R5
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i_mask && (x_mask || !nmi_req)) |-> !take_irq);

  // R6
  nmi_over_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_win |-> !mask_win);

  // R8
  mask_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_stb && mask_win) |=> (i_mask && x_mask == $past(x_mask) && !sel_nmi));

  // R9
  nmi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_stb && nmi_win) |=> (x_mask && i_mask && sel_nmi));

  // R10
  rti_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_stb && !(entry_stb && take_irq)) |=> (x_mask == $past(rti_x) && i_mask == $past(rti_i)));

  // R11
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(entry_stb && take_irq) |=> ($stable(sel_idx) && $stable(sel_nmi)));

  // R12
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_stb && !take_irq && !rti_stb && !sw_wr) |=> ($stable(x_mask) && $stable(i_mask)));

  // R5
  take_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (nmi_req || any_req));
endmodule

bind irq_mask_arbiter irq_mask_arbiter_chk #(.IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .nmi_req   (nmi_req),
  .any_req   (|mreq),
  .sw_wr     (sw_wr),
  .entry_stb (entry_stb),
  .rti_stb   (rti_stb),
  .rti_x     (rti_x),
  .rti_i     (rti_i),
  .x_mask    (x_mask),
  .i_mask    (i_mask),
  .take_irq  (take_irq),
  .nmi_win   (nmi_win),
  .mask_win  (mask_win),
  .sel_idx   (sel_idx),
  .sel_nmi   (sel_nmi)
);

// File: tb/irq_mask_arbiter_tb.sv
module irq_mask_arbiter_tb;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_req = 1'b0;
  logic [N-1:0] mreq = '0;
  logic sw_wr = 1'b0, sw_x = 1'b0, sw_i = 1'b0;
  logic entry_stb = 1'b0, rti_stb = 1'b0, rti_x = 1'b0, rti_i = 1'b0;
  logic x_mask, i_mask, take_irq, sel_nmi;
  logic [IW-1:0] sel_idx;

  always #10 clk = ~clk;  // 50 MHz

  irq_mask_arbiter #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .mreq(mreq),
    .sw_wr(sw_wr), .sw_x(sw_x), .sw_i(sw_i), .entry_stb(entry_stb),
    .rti_stb(rti_stb), .rti_x(rti_x), .rti_i(rti_i),
    .x_mask(x_mask), .i_mask(i_mask), .take_irq(take_irq),
    .sel_idx(sel_idx), .sel_nmi(sel_nmi)
  );

  typedef struct {
    string         tag;
    logic          x, i, t, n;
    logic [IW-1:0] idx;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  event chk_ev;

  // bench model state
  logic mx = 1'b1, mi = 1'b1, mn = 1'b0;
  logic [IW-1:0] mid = '0;

  function automatic logic [IW-1:0] first_one(input logic [N-1:0] v);
    logic [IW-1:0] r = '0;
    for (int k = N - 1; k >= 0; k--) if (v[k]) r = IW'(k);
    return r;
  endfunction

  function automatic logic pend(input logic nm, input logic [N-1:0] mr, input logic x, input logic i);
    return (nm && !x) || ((mr != '0) && !i);
  endfunction

  // monitor: pop and compare
  always @(chk_ev) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (x_mask !== e.x || i_mask !== e.i || take_irq !== e.t ||
          sel_nmi !== e.n || sel_idx !== e.idx) begin
        failures++;
        $display("FAIL %s: got x=%b i=%b take=%b nmi=%b idx=%0d exp x=%b i=%b take=%b nmi=%b idx=%0d",
                 e.tag, x_mask, i_mask, take_irq, sel_nmi, sel_idx,
                 e.x, e.i, e.t, e.n, e.idx);
      end
    end
  end

  task automatic push_exp(input string tag);
    exp_t e;
    e.tag = tag; e.x = mx; e.i = mi; e.n = mn; e.idx = mid;
    e.t = pend(nmi_req, mreq, mx, mi);
    q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  // one clock with stimulus; levels persist, strobes last one cycle
  task automatic step(input string tag, input logic nm, input logic [N-1:0] mr,
                      input logic sw, input logic swx, input logic swi,
                      input logic en, input logic rt, input logic rtx, input logic rti);
    logic tk;
    @(negedge clk);
    nmi_req = nm; mreq = mr; sw_wr = sw; sw_x = swx; sw_i = swi;
    entry_stb = en; rti_stb = rt; rti_x = rtx; rti_i = rti;
    tk = pend(nm, mr, mx, mi);
    if (en && tk) begin
      if (nm && !mx) begin mx = 1'b1; mi = 1'b1; mn = 1'b1; mid = '0; end
      else begin mi = 1'b1; mn = 1'b0; mid = first_one(mr); end
    end else if (rt) begin
      mx = rtx; mi = rti;
    end else if (sw) begin
      if (!swx) mx = 1'b0;
      mi = swi;
    end
    @(posedge clk);
    @(negedge clk);
    sw_wr = 1'b0; entry_stb = 1'b0; rti_stb = 1'b0;
    #1;
    push_exp(tag);
  endtask

  task automatic run();
    // R1: reset state with all requests raised
    @(negedge clk);
    nmi_req = 1'b1; mreq = '1;
    #1;
    push_exp("R1");
    @(negedge clk);
    rst_n = 1'b1;
    // R3: software clears I, X write of 1 keeps X at 1
    step("R3", 0, '0, 1, 1, 0, 0, 0, 0, 0);
    // R2: software clears X, sets I
    step("R2", 0, '0, 1, 0, 1, 0, 0, 0, 0);
    // R2: software cannot set X again
    step("R2", 0, '0, 1, 1, 1, 0, 0, 0, 0);
    // R4: nmi open with I set
    step("R4", 1, '0, 0, 0, 0, 0, 0, 0, 0);
    // R9: take nmi
    step("R9", 1, '0, 0, 0, 0, 1, 0, 0, 0);
    // R12: entry with nothing pending (x=1 blocks nmi)
    step("R12", 1, '0, 0, 0, 0, 1, 0, 0, 0);
    // R10: restore both clear
    step("R10", 0, 8'b0010_1100, 0, 0, 0, 0, 1, 0, 0);
    // R7 / R8: take maskable, lowest index 2
    step("R7", 0, 8'b0010_1100, 0, 0, 0, 1, 0, 0, 0);
    // R5: masked requests with I set, entry ignored
    step("R5", 0, 8'b0110_0000, 0, 0, 0, 1, 0, 0, 0);
    // R11: selection holds across plain cycles
    step("R11", 0, 8'b0000_0001, 0, 0, 0, 0, 0, 0, 0);
    // R8: clear I then take index 7, X stays 0
    step("R3", 0, 8'b1000_0000, 1, 1, 0, 0, 0, 0, 0);
    step("R8", 0, 8'b1000_0000, 0, 0, 0, 1, 0, 0, 0);
    // R6: nmi and maskable together
    step("R10", 0, '0, 0, 0, 0, 0, 1, 0, 0);
    step("R6", 1, 8'b0000_0011, 0, 0, 0, 1, 0, 0, 0);
    // R13: return beats software write
    step("R13", 0, '0, 1, 0, 1, 0, 1, 0, 0);
    // R10: restore sets X back to 1
    step("R10", 0, '0, 0, 0, 0, 0, 1, 1, 0);
    // R13: taken entry beats return (maskable index 4)
    step("R13", 0, 8'b0001_0000, 0, 0, 0, 1, 1, 0, 0);
    // R12: entry with no requests
    step("R12", 0, '0, 0, 0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    logic wd;
    wd = 1'b0;
    fork
      run();
      begin repeat (5000) @(posedge clk); wd = 1'b1; end
    join_any
    disable fork;
    #2;
    if (wd) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule